// File: doc/BRIEF.md
# System Clock Selector with Crystal Failover

This block picks the clock that drives the system from four candidate sources: a multi-speed RC oscillator, a 16 MHz RC oscillator, a 32 MHz external crystal oscillator and the R output of the PLL. Each source arrives as a free-running clock plus a ready bit. Software asks for a new source with a one-cycle request. The block waits until that source is ready and then hands the output over glitch-free. The old source is first gated off in its own clock domain, and only then is the new one gated on in its domain. A status field names the source that is actually carrying the output.

The external oscillator has a failure monitor. When the monitor reports a fault, the block drops that oscillator at once. It falls back to the 16 MHz RC, or to the multi-speed RC if the 16 MHz RC is not ready. It also raises a non-maskable interrupt and a break line for the timers. Both stay high until software clears the fault. Until then, requests for the external oscillator are refused. A fault on the low-speed external oscillator only raises an interrupt that software can mask.

Wakeup events choose a default source without software help. Standby wakeup selects the multi-speed RC. Stop wakeup selects the 16 MHz RC or the multi-speed RC, depending on a configuration bit.

Top module: `sysclk_selector`

## Requirements
- R1: After reset the status field reads 0 and the non-maskable interrupt, timer break and low-speed interrupt are low. The output carries the multi-speed RC. Source codes are: 0 multi-speed RC, 1 16 MHz RC, 2 external oscillator, 3 PLL R output. Bit i of `src_clk_i` and `src_rdy_i` belongs to code i.
- R2: A software request (`sw_req_i` high for one cycle, code on `sw_sel_i`) moves the output to the requested source. The status field changes to the new code only once that source's gate is open, and the output then toggles at that source's rate.
- R3: While the requested source's ready bit is low, the status and the output stay on the old source. The switch completes after the ready bit rises.
- R4: Every high and every low phase of `sys_clk_o` lasts at least the shortest half-period among the sources, including across switches and failover.
- R5: A Standby wakeup pulse selects code 0.
- R6: A Stop wakeup pulse selects code 1 when `stop_wk_rc16_i` is high and code 0 when it is low.
- R7: An external-oscillator fault sampled on a clock edge drives `nmi_o` and `tim_brk_o` high in the cycle that follows. If the output ran on code 2, it moves to code 1, or to code 0 when code 1 is not ready.
- R8: `nmi_o` and `tim_brk_o` hold until `fail_clr_i` is sampled while `xosc_fail_i` is low. They fall in the next cycle.
- R9: While the fault is pending, a request for code 2 is ignored and the status stays unchanged. After the fault is cleared, such a request is served.
- R10: A low-speed oscillator fault sets a flag that `fail_clr_i` clears. `lse_irq_o` equals that flag ANDed with `lse_irq_en_i`, and the fault never drives `nmi_o`.
- R11: A request for the source already active changes neither the status nor the output clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on control clock |
| rst_i | input | 1 | Synchronous active-high reset, control domain |
| src_clk_i | input | 4 | Source clocks, bit i is code i |
| src_rdy_i | input | 4 | Source ready bits, control domain |
| sw_req_i | input | 1 | One-cycle software switch request |
| sw_sel_i | input | 2 | Requested source code |
| wake_stby_i | input | 1 | Standby wakeup pulse |
| wake_stop_i | input | 1 | Stop wakeup pulse |
| stop_wk_rc16_i | input | 1 | Stop wakeup picks the 16 MHz RC when high |
| xosc_fail_i | input | 1 | External-oscillator failure from its monitor |
| fail_clr_i | input | 1 | Clears the fault flags |
| lse_fail_i | input | 1 | Low-speed external oscillator failure |
| lse_irq_en_i | input | 1 | Mask enable for the low-speed fault interrupt |
| sys_clk_o | output | 1 | Selected system clock |
| sel_stat_o | output | 2 | Code of the source carrying the output |
| nmi_o | output | 1 | Non-maskable interrupt on crystal fault |
| tim_brk_o | output | 1 | Break line to the timers on crystal fault |
| lse_irq_o | output | 1 | Maskable low-speed fault interrupt |

## Verification
The fault flags live in the control domain. `nmi_o`, `tim_brk_o` and `lse_irq_o` are due on the first rising edge after the input is sampled, and the bench reads them on the falling edge that follows. Status changes cross two synchronizers in each direction and depend on the source periods, so they have no fixed cycle count. The scoreboard queues each expected code before the stimulus and pops it when the status moves. A ceiling of 400 control cycles applies to each expected change, and any change that arrives with the queue empty counts as a miscompare. After each handover the bench waits several source periods and then checks the measured high phase of the output against the expected source.

// File: rtl/sysclk_sel_pkg.sv
package sysclk_sel_pkg;

    localparam int unsigned NUM_SRC = 4;
    localparam int unsigned SEL_W   = $clog2(NUM_SRC);

    typedef enum logic [SEL_W-1:0] {
        SRC_MSRC = 2'd0,
        SRC_RC16 = 2'd1,
        SRC_XOSC = 2'd2,
        SRC_PLLR = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_WAIT,
        SW_DRAIN,
        SW_LAUNCH
    } sw_state_e;

    typedef struct packed {
        logic valid;
        src_e tgt;
    } sel_req_t;

    function automatic logic [NUM_SRC-1:0] src_bit(src_e s);
        logic [NUM_SRC-1:0] r;
        r = '0;
        r[s] = 1'b1;
        return r;
    endfunction

    function automatic src_e backup_pick(logic rc16_ready);
        return rc16_ready ? SRC_RC16 : SRC_MSRC;
    endfunction

    function automatic src_e wake_pick(logic from_stby, logic use_rc16);
        if (from_stby) begin
            return SRC_MSRC;
        end
        return use_rc16 ? SRC_RC16 : SRC_MSRC;
    endfunction

endpackage

// File: rtl/sysclk_lane.sv
module sysclk_lane #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic src_clk_i,
    input  logic en_i,
    input  logic kill_i,
    output logic gclk_o,
    output logic ack_o
);

    logic [STAGES-1:0] en_sync;
    logic              gate_q;
    logic [STAGES-1:0] ack_sync;

    // Enable brought into the source domain; kill clears it without a source edge.
    always_ff @(posedge src_clk_i or posedge kill_i) begin
        if (kill_i) begin
            en_sync <= '0;
        end else begin
            en_sync <= (en_sync << 1) | STAGES'(en_i);
        end
    end

    // Gate changes only while the source is low.
    always_ff @(negedge src_clk_i or posedge kill_i) begin
        if (kill_i) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= en_sync[STAGES-1];
        end
    end

    assign gclk_o = src_clk_i & gate_q;

    // Gate state returned to the control domain.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ack_sync <= '0;
        end else begin
            ack_sync <= (ack_sync << 1) | STAGES'(gate_q);
        end
    end

    assign ack_o = ack_sync[STAGES-1];

endmodule

// File: rtl/sysclk_fault.sv
module sysclk_fault (
    input  logic clk_i,
    input  logic rst_i,
    input  logic xosc_fail_i,
    input  logic lse_fail_i,
    input  logic clr_i,
    input  logic lse_en_i,
    output logic xflag_o,
    output logic xevt_o,
    output logic lse_irq_o
);

    logic xflag_q;
    logic lflag_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            xflag_q <= 1'b0;
            lflag_q <= 1'b0;
        end else begin
            if (xosc_fail_i) begin
                xflag_q <= 1'b1;
            end else if (clr_i) begin
                xflag_q <= 1'b0;
            end
            if (lse_fail_i) begin
                lflag_q <= 1'b1;
            end else if (clr_i) begin
                lflag_q <= 1'b0;
            end
        end
    end

    assign xflag_o   = xflag_q;
    assign xevt_o    = xosc_fail_i & ~xflag_q;
    assign lse_irq_o = lflag_q & lse_en_i;

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
    import sysclk_sel_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] rdy_i,
    input  logic [NUM_SRC-1:0] ack_i,
    input  logic               sw_req_i,
    input  logic [SEL_W-1:0]   sw_sel_i,
    input  logic               wake_stby_i,
    input  logic               wake_stop_i,
    input  logic               stop_rc16_i,
    input  logic               xevt_i,
    input  logic               xflag_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] kill_o,
    output logic [SEL_W-1:0]   cur_o
);

    sw_state_e          st_q, st_n;
    src_e               cur_q, cur_n;
    src_e               tgt_q, tgt_n;
    logic [NUM_SRC-1:0] en_q, en_n;
    logic [NUM_SRC-1:0] kill_q, kill_n;
    sel_req_t           wk_q, wk_n;
    sel_req_t           req;
    src_e               sw_src;
    logic               xosc_involved;

    assign sw_src        = src_e'(sw_sel_i);
    assign xosc_involved = (cur_q == SRC_XOSC) || ((st_q != SW_IDLE) && (tgt_q == SRC_XOSC));

    // Pending wakeup first, then a software request not aimed at a faulted crystal.
    always_comb begin
        req = '0;
        if (wk_q.valid) begin
            req = wk_q;
        end else if (sw_req_i && !(sw_src == SRC_XOSC && xflag_i)) begin
            req.valid = 1'b1;
            req.tgt   = sw_src;
        end
    end

    always_comb begin
        st_n   = st_q;
        cur_n  = cur_q;
        tgt_n  = tgt_q;
        en_n   = en_q;
        wk_n   = wk_q;
        kill_n = '0;
        kill_n[SRC_XOSC] = kill_q[SRC_XOSC] & xflag_i;

        unique case (st_q)
            SW_IDLE, SW_WAIT: begin
                if (req.valid) begin
                    wk_n.valid = 1'b0;
                    if (req.tgt == cur_q) begin
                        st_n = SW_IDLE;
                    end else begin
                        tgt_n = req.tgt;
                        st_n  = SW_WAIT;
                    end
                end else if (st_q == SW_WAIT && rdy_i[tgt_q]) begin
                    en_n = '0;
                    st_n = SW_DRAIN;
                end
            end
            SW_DRAIN: begin
                if (ack_i == '0 && rdy_i[tgt_q]) begin
                    en_n = src_bit(tgt_q);
                    st_n = SW_LAUNCH;
                end
            end
            SW_LAUNCH: begin
                if (ack_i[tgt_q]) begin
                    cur_n = tgt_q;
                    st_n  = SW_IDLE;
                end
            end
            default: st_n = SW_IDLE;
        endcase

        if (wake_stby_i || wake_stop_i) begin
            wk_n.valid = 1'b1;
            wk_n.tgt   = wake_pick(wake_stby_i, stop_rc16_i);
        end

        // Crystal fault overrides any step of a switch.
        if (xevt_i && xosc_involved) begin
            tgt_n            = backup_pick(rdy_i[SRC_RC16]);
            en_n             = '0;
            kill_n[SRC_XOSC] = 1'b1;
            st_n             = SW_DRAIN;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q   <= SW_IDLE;
            cur_q  <= SRC_MSRC;
            tgt_q  <= SRC_MSRC;
            en_q   <= src_bit(SRC_MSRC);
            kill_q <= ~src_bit(SRC_MSRC);
            wk_q   <= '0;
        end else begin
            st_q   <= st_n;
            cur_q  <= cur_n;
            tgt_q  <= tgt_n;
            en_q   <= en_n;
            kill_q <= kill_n;
            wk_q   <= wk_n;
        end
    end

    assign en_o   = en_q;
    assign kill_o = kill_q;
    assign cur_o  = cur_q;

endmodule

// File: rtl/sysclk_selector.sv
module sysclk_selector
    import sysclk_sel_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] src_clk_i,
    input  logic [NUM_SRC-1:0] src_rdy_i,
    input  logic               sw_req_i,
    input  logic [SEL_W-1:0]   sw_sel_i,
    input  logic               wake_stby_i,
    input  logic               wake_stop_i,
    input  logic               stop_wk_rc16_i,
    input  logic               xosc_fail_i,
    input  logic               fail_clr_i,
    input  logic               lse_fail_i,
    input  logic               lse_irq_en_i,
    output logic               sys_clk_o,
    output logic [SEL_W-1:0]   sel_stat_o,
    output logic               nmi_o,
    output logic               tim_brk_o,
    output logic               lse_irq_o
);

    logic [NUM_SRC-1:0] lane_en;
    logic [NUM_SRC-1:0] lane_kill;
    logic [NUM_SRC-1:0] lane_ack;
    logic [NUM_SRC-1:0] lane_clk;
    logic               xflag;
    logic               xevt;

    sysclk_fault u_fault (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .xosc_fail_i (xosc_fail_i),
        .lse_fail_i  (lse_fail_i),
        .clr_i       (fail_clr_i),
        .lse_en_i    (lse_irq_en_i),
        .xflag_o     (xflag),
        .xevt_o      (xevt),
        .lse_irq_o   (lse_irq_o)
    );

    sysclk_ctrl u_ctrl (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .rdy_i       (src_rdy_i),
        .ack_i       (lane_ack),
        .sw_req_i    (sw_req_i),
        .sw_sel_i    (sw_sel_i),
        .wake_stby_i (wake_stby_i),
        .wake_stop_i (wake_stop_i),
        .stop_rc16_i (stop_wk_rc16_i),
        .xevt_i      (xevt),
        .xflag_i     (xflag),
        .en_o        (lane_en),
        .kill_o      (lane_kill),
        .cur_o       (sel_stat_o)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        sysclk_lane #(
            .STAGES (SYNC_STAGES)
        ) u_lane (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .src_clk_i (src_clk_i[i]),
            .en_i      (lane_en[i]),
            .kill_i    (lane_kill[i]),
            .gclk_o    (lane_clk[i]),
            .ack_o     (lane_ack[i])
        );
    end

    assign sys_clk_o = |lane_clk;
    assign nmi_o     = xflag;
    assign tim_brk_o = xflag;

endmodule

// File: rtl/sysclk_selector_chk.sv
module sysclk_selector_chk
    import sysclk_sel_pkg::*;
(
    input logic               clk_i,
    input logic               rst_i,
    input logic [SEL_W-1:0]   sel_stat_o,
    input logic               nmi_o,
    input logic               tim_brk_o,
    input logic               lse_irq_o,
    input logic               lse_irq_en_i,
    input logic               lse_fail_i,
    input logic               xosc_fail_i,
    input logic               fail_clr_i,
    input logic [NUM_SRC-1:0] lane_ack
);

    // R2: a new status code names a lane whose gate is open
    assert_status_on_live_lane_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(sel_stat_o) |-> lane_ack[sel_stat_o]);

    // R4: never two gates open at once
    assert_single_lane_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(lane_ack));

    assert_nmi_after_fault_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        xosc_fail_i |=> nmi_o);

    assert_brk_after_fault_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        xosc_fail_i |=> tim_brk_o);

    assert_nmi_cause_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(nmi_o) |-> $past(xosc_fail_i));

    assert_flag_hold_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (nmi_o && !fail_clr_i) |=> nmi_o);

    assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (fail_clr_i && !xosc_fail_i) |=> !nmi_o);

    assert_no_xosc_while_fault_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (nmi_o && !$stable(sel_stat_o)) |-> (sel_stat_o != SRC_XOSC));

    assert_lse_mask_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        lse_fail_i |=> (lse_irq_o == lse_irq_en_i));

endmodule

bind sysclk_selector sysclk_selector_chk u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .sel_stat_o   (sel_stat_o),
    .nmi_o        (nmi_o),
    .tim_brk_o    (tim_brk_o),
    .lse_irq_o    (lse_irq_o),
    .lse_irq_en_i (lse_irq_en_i),
    .lse_fail_i   (lse_fail_i),
    .xosc_fail_i  (xosc_fail_i),
    .fail_clr_i   (fail_clr_i),
    .lane_ack     (lane_ack)
);

// File: tb/sysclk_selector_bench.sv
`timescale 1ns/1ps
module sysclk_selector_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] src_clk = 4'b0;
    logic [3:0] src_rdy = 4'b1111;
    logic       sw_req = 1'b0;
    logic [1:0] sw_sel = 2'd0;
    logic       wake_stby = 1'b0;
    logic       wake_stop = 1'b0;
    logic       stop_rc16 = 1'b0;
    logic       xosc_fail = 1'b0;
    logic       fail_clr = 1'b0;
    logic       lse_fail = 1'b0;
    logic       lse_en = 1'b0;
    logic       sys_clk;
    logic [1:0] sel_stat;
    logic       nmi;
    logic       brk;
    logic       lse_irq;
    logic       xosc_run = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [1:0] code;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    logic [1:0] last_stat = 2'd0;
    bit         mon_on = 1'b0;
    int         glitches = 0;
    realtime    t_edge = 0.0;
    real        hi_w = 0.0;
    bit         edge_seen = 1'b0;

    always #2 clk = ~clk;
    always #7 src_clk[0] = ~src_clk[0];
    always #5 src_clk[1] = ~src_clk[1];
    always begin
        #4;
        if (xosc_run) src_clk[2] = ~src_clk[2];
        else          src_clk[2] = 1'b0;
    end
    always #3 src_clk[3] = ~src_clk[3];

    sysclk_selector u_sysclk_selector (
        .clk_i          (clk),
        .rst_i          (rst),
        .src_clk_i      (src_clk),
        .src_rdy_i      (src_rdy),
        .sw_req_i       (sw_req),
        .sw_sel_i       (sw_sel),
        .wake_stby_i    (wake_stby),
        .wake_stop_i    (wake_stop),
        .stop_wk_rc16_i (stop_rc16),
        .xosc_fail_i    (xosc_fail),
        .fail_clr_i     (fail_clr),
        .lse_fail_i     (lse_fail),
        .lse_irq_en_i   (lse_en),
        .sys_clk_o      (sys_clk),
        .sel_stat_o     (sel_stat),
        .nmi_o          (nmi),
        .tim_brk_o      (brk),
        .lse_irq_o      (lse_irq)
    );

    function automatic real half_of(logic [1:0] c);
        case (c)
            2'd0:    return 7.0;
            2'd1:    return 5.0;
            2'd2:    return 4.0;
            default: return 3.0;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Output phase widths (R4) and last high phase
    always @(sys_clk) begin
        if (mon_on) begin
            if (edge_seen && ($realtime - t_edge) < 2.9) glitches++;
            if (!sys_clk && edge_seen) hi_w = $realtime - t_edge;
            t_edge    = $realtime;
            edge_seen = 1'b1;
        end
    end

    // Scoreboard monitor: each status change pops one expected item
    always @(negedge clk) begin
        if (mon_on && sel_stat != last_stat) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected status change", int'(sel_stat), int'(last_stat));
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(sel_stat == e.code, e.req, int'(sel_stat), int'(e.code));
            end
            last_stat = sel_stat;
        end
    end

    task automatic wait_drained(string req);
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic check_rate(logic [1:0] c, string req);
        repeat (30) @(negedge clk);
        check((hi_w > half_of(c) - 0.01) && (hi_w < half_of(c) + 0.01), req,
              int'(hi_w * 1000.0), int'(half_of(c) * 1000.0));
    endtask

    task automatic push(logic [1:0] c, string req);
        exp_t e;
        e.code = c;
        e.req  = req;
        exp_q.push_back(e);
    endtask

    task automatic sw_to(logic [1:0] c);
        sw_sel = c;
        sw_req = 1'b1;
        tick();
        sw_req = 1'b0;
    endtask

    task automatic quiet_check(logic [1:0] c, string req);
        repeat (80) @(negedge clk);
        check(sel_stat == c, req, int'(sel_stat), int'(c));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) tick();
        rst = 1'b0;
        mon_on = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(sel_stat == 2'd0, "R1 status after reset", int'(sel_stat), 0);
        check(!nmi && !brk && !lse_irq, "R1 flags after reset", int'({nmi, brk, lse_irq}), 0);
        check_rate(2'd0, "R1 output runs on multi-speed RC");

        // R2: switch to 16 MHz RC
        push(2'd1, "R2 switch to code 1");
        tick();
        sw_to(2'd1);
        wait_drained("R2 switch to code 1 completes");
        check_rate(2'd1, "R2 output rate code 1");

        // R3: PLL not ready holds the switch
        src_rdy[3] = 1'b0;
        sw_to(2'd3);
        quiet_check(2'd1, "R3 status held while not ready");
        check_rate(2'd1, "R3 output held while not ready");
        push(2'd3, "R3 switch after ready");
        src_rdy[3] = 1'b1;
        wait_drained("R3 switch after ready completes");
        check_rate(2'd3, "R3 output rate code 3");

        // R11: request for the active source
        sw_to(2'd3);
        quiet_check(2'd3, "R11 same-source request");
        check_rate(2'd3, "R11 output unchanged");

        // R2: switch to external oscillator
        push(2'd2, "R2 switch to code 2");
        sw_to(2'd2);
        wait_drained("R2 switch to code 2 completes");
        check_rate(2'd2, "R2 output rate code 2");

        // R7: crystal fault, backup is the 16 MHz RC
        xosc_run = 1'b0;
        repeat (4) tick();
        push(2'd1, "R7 failover to code 1");
        xosc_fail = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(nmi == 1'b1, "R7 nmi after fault", int'(nmi), 1);
        check(brk == 1'b1, "R7 break after fault", int'(brk), 1);
        wait_drained("R7 failover completes");
        check_rate(2'd1, "R7 output rate after failover");

        // R9: external oscillator request refused while fault pending
        #1;
        sw_to(2'd2);
        quiet_check(2'd1, "R9 request ignored during fault");

        // R8: clear ignored while the fault persists; flag holds without clear
        fail_clr = 1'b1;
        tick();
        fail_clr = 1'b0;
        @(negedge clk);
        check(nmi == 1'b1, "R8 nmi held while fault present", int'(nmi), 1);
        xosc_fail = 1'b0;
        xosc_run  = 1'b1;
        repeat (5) tick();
        check(nmi == 1'b1 && brk == 1'b1, "R8 flags held until clear", int'({nmi, brk}), 3);
        fail_clr = 1'b1;
        tick();
        fail_clr = 1'b0;
        @(negedge clk);
        check(nmi == 1'b0 && brk == 1'b0, "R8 flags cleared", int'({nmi, brk}), 0);

        // R9: after clear the request is served
        push(2'd2, "R9 switch to code 2 after clear");
        #1;
        sw_to(2'd2);
        wait_drained("R9 switch after clear completes");

        // R7: backup falls to multi-speed RC when 16 MHz RC is not ready
        src_rdy[1] = 1'b0;
        xosc_run = 1'b0;
        repeat (4) tick();
        push(2'd0, "R7 failover to code 0");
        xosc_fail = 1'b1;
        tick();
        xosc_fail = 1'b0;
        wait_drained("R7 failover to code 0 completes");
        check_rate(2'd0, "R7 output rate code 0");
        #1;
        fail_clr = 1'b1;
        tick();
        fail_clr = 1'b0;
        src_rdy[1] = 1'b1;
        xosc_run = 1'b1;

        // R5: standby wakeup from PLL
        push(2'd3, "R5 setup code 3");
        sw_to(2'd3);
        wait_drained("R5 setup completes");
        push(2'd0, "R5 standby wake to code 0");
        #1;
        wake_stby = 1'b1;
        tick();
        wake_stby = 1'b0;
        wait_drained("R5 standby wake completes");

        // R6: stop wakeup with configuration bit set, then clear
        push(2'd2, "R6 setup code 2");
        #1;
        sw_to(2'd2);
        wait_drained("R6 setup completes");
        push(2'd1, "R6 stop wake to code 1");
        #1;
        stop_rc16 = 1'b1;
        wake_stop = 1'b1;
        tick();
        wake_stop = 1'b0;
        wait_drained("R6 stop wake code 1 completes");
        push(2'd0, "R6 stop wake to code 0");
        #1;
        stop_rc16 = 1'b0;
        wake_stop = 1'b1;
        tick();
        wake_stop = 1'b0;
        wait_drained("R6 stop wake code 0 completes");

        // R10: low-speed fault is maskable and never an NMI
        #1;
        lse_en = 1'b0;
        lse_fail = 1'b1;
        tick();
        lse_fail = 1'b0;
        @(negedge clk);
        check(lse_irq == 1'b0, "R10 masked interrupt", int'(lse_irq), 0);
        check(nmi == 1'b0, "R10 no nmi on low-speed fault", int'(nmi), 0);
        #1;
        lse_en = 1'b1;
        #1;
        check(lse_irq == 1'b1, "R10 unmasked pending flag", int'(lse_irq), 1);
        fail_clr = 1'b1;
        tick();
        fail_clr = 1'b0;
        @(negedge clk);
        check(lse_irq == 1'b0, "R10 cleared", int'(lse_irq), 0);

        // R4: no short phase anywhere in the run
        repeat (10) tick();
        check(glitches == 0, "R4 short output phases", glitches, 0);
        finish_run();
    end

endmodule